// File: doc/BRIEF.md
# Cross Trigger Event Router

This block carries short debug events between on-chip components. Trigger inputs feed a small set of shared broadcast channels, and each trigger output looks at those channels through its own mask. Routing therefore has two steps. An input lights every channel in its input mask. An output fires when any channel in its output mask is lit. Software can also raise channels directly. It can hold a channel on, release it, or give it a one-cycle kick.

Trigger outputs are sticky. Once set, an output stays high until software acknowledges it. A global enable gates whether any output can become set.

All configuration goes through a plain 32-bit register bus addressed in bytes, with word-aligned offsets. A key-guarded lock protects every register except the lock register itself. Reads are combinational on the address, and writes take effect at the clock edge. Reset leaves the block locked and disabled, with every mask cleared.

Top module: `xtrig_router`

## Requirements
- R1: After reset, trig_out is 0, the control register (0x000) reads 0, every mask reads 0, and the lock status register (0xFB4) reads 0x3. Bit 0 of 0xFB4 means "lock present" and bit 1 means "locked".
- R2: Writing UNLOCK_KEY to 0xFB0 clears the lock, so 0xFB4 reads 0x1. Writing any other value sets the lock. While locked, writes to every other offset leave the state unchanged.
- R3: The mask for input n is at 0x020+4n and the mask for output m is at 0x0A0+4m. Each reads back the written bits [N_CH-1:0], with the upper bits reading 0.
- R4: With enable (bit 0 of 0x000) set, suppose input n is high and channel c is in both input n's mask and output m's mask. Then trig_out[m] is 1 after the next clock edge.
- R5: A set trig_out[m] stays high after its cause goes away. Writing 0x010 with bit m set clears it at the next edge. Ack bits for other outputs do not affect it.
- R6: If an ack of output m and a fresh hit on output m land on the same edge, the output stays set.
- R7: While enable is 0, no trigger output goes from 0 to 1.
- R8: Writing 1s to 0x014 holds those channels active, and writing 1s to 0x018 releases them. A held channel drives outputs like a triggered one. 0x014 reads back the held set.
- R9: Writing 1s to 0x01C makes those channels active for exactly the one cycle after the write.
- R10: The status registers read as follows. 0x130 returns trig_in. 0x134 returns trig_out. 0x138 returns the channels raised by trigger inputs. 0x13C returns all active channels.
- R11: An unmapped offset reads 0. Offsets 0xFE0+4i (i = 0..7) read ID_CODE byte i in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| trig_in | input | N_TI | Trigger input events |
| trig_out | output | N_TO | Latched trigger outputs |

## Verification
The contested cycle is one where an acknowledge write to an output and a new routed hit on the same output reach the same clock edge. The bench keeps the routed trigger input high while it issues the ack. It then expects the output to stay high, and only after dropping the input does a second ack clear it. A second overlap is between an application pulse and the sticky outputs. The bench checks that the channel status shows the pulse for one cycle only, while the output it drove remains latched afterwards.

// File: rtl/xtrig_router.sv
module xtrig_router #(
  parameter int          N_TI       = 8,
  parameter int          N_TO       = 8,
  parameter int          N_CH       = 4,
  parameter int          AW         = 12,
  parameter logic [31:0] UNLOCK_KEY = 32'h5EC0_17AB,
  parameter logic [63:0] ID_CODE    = 64'h0DE1_7A2C_00B9_0433
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [N_TI-1:0] trig_in,
  output logic [N_TO-1:0] trig_out
);
  localparam logic [AW-1:0] A_CTRL  = AW'(12'h000);
  localparam logic [AW-1:0] A_ACK   = AW'(12'h010);
  localparam logic [AW-1:0] A_SET   = AW'(12'h014);
  localparam logic [AW-1:0] A_CLR   = AW'(12'h018);
  localparam logic [AW-1:0] A_PULSE = AW'(12'h01C);
  localparam int            A_INM   = 12'h020;
  localparam int            A_OUTM  = 12'h0A0;
  localparam logic [AW-1:0] A_STTI  = AW'(12'h130);
  localparam logic [AW-1:0] A_STTO  = AW'(12'h134);
  localparam logic [AW-1:0] A_STCI  = AW'(12'h138);
  localparam logic [AW-1:0] A_STCO  = AW'(12'h13C);
  localparam logic [AW-1:0] A_LAR   = AW'(12'hFB0);
  localparam logic [AW-1:0] A_LSR   = AW'(12'hFB4);
  localparam int            A_ID    = 12'hFE0;
  localparam int            N_ID    = 8;

  logic            en_q, locked_q;
  logic [N_CH-1:0] in_mask_q [N_TI];
  logic [N_CH-1:0] out_mask_q [N_TO];
  logic [N_CH-1:0] app_q, pulse_q, chan_trig, chan_act;
  logic [N_TO-1:0] trig_q, out_hit, ack_bits;

  wire wr_ok = bus_wr & ~locked_q;

  assign trig_out = trig_q;
  assign ack_bits = (wr_ok && bus_addr == A_ACK) ? bus_wdata[N_TO-1:0] : '0;

  always_comb begin
    chan_trig = '0;
    for (int n = 0; n < N_TI; n++)
      if (trig_in[n]) chan_trig = chan_trig | in_mask_q[n];
  end

  assign chan_act = chan_trig | app_q | pulse_q;

  for (genvar m = 0; m < N_TO; m++) begin : g_out
    assign out_hit[m] = en_q & (|(chan_act & out_mask_q[m]));
    always_ff @(posedge clk)
      if (!rst_n) out_mask_q[m] <= '0;
      else if (wr_ok && bus_addr == AW'(A_OUTM + 4*m)) out_mask_q[m] <= bus_wdata[N_CH-1:0];
  end

  for (genvar n = 0; n < N_TI; n++) begin : g_in
    always_ff @(posedge clk)
      if (!rst_n) in_mask_q[n] <= '0;
      else if (wr_ok && bus_addr == AW'(A_INM + 4*n)) in_mask_q[n] <= bus_wdata[N_CH-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      locked_q <= 1'b1;
      app_q    <= '0;
      pulse_q  <= '0;
      trig_q   <= '0;
    end else begin
      if (bus_wr && bus_addr == A_LAR) locked_q <= (bus_wdata != UNLOCK_KEY);
      if (wr_ok && bus_addr == A_CTRL) en_q <= bus_wdata[0];
      if (wr_ok && bus_addr == A_SET)      app_q <= app_q | bus_wdata[N_CH-1:0];
      else if (wr_ok && bus_addr == A_CLR) app_q <= app_q & ~bus_wdata[N_CH-1:0];
      pulse_q <= (wr_ok && bus_addr == A_PULSE) ? bus_wdata[N_CH-1:0] : '0;
      trig_q  <= (trig_q & ~ack_bits) | out_hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[0]        = en_q;
      A_SET:  bus_rdata[N_CH-1:0] = app_q;
      A_STTI: bus_rdata[N_TI-1:0] = trig_in;
      A_STTO: bus_rdata[N_TO-1:0] = trig_q;
      A_STCI: bus_rdata[N_CH-1:0] = chan_trig;
      A_STCO: bus_rdata[N_CH-1:0] = chan_act;
      A_LSR:  bus_rdata[1:0]      = {locked_q, 1'b1};
      default: ;
    endcase
    for (int n = 0; n < N_TI; n++)
      if (bus_addr == AW'(A_INM + 4*n)) bus_rdata[N_CH-1:0] = in_mask_q[n];
    for (int m = 0; m < N_TO; m++)
      if (bus_addr == AW'(A_OUTM + 4*m)) bus_rdata[N_CH-1:0] = out_mask_q[m];
    for (int i = 0; i < N_ID; i++)
      if (bus_addr == AW'(A_ID + 4*i)) bus_rdata[7:0] = ID_CODE[i*8 +: 8];
  end
endmodule

// File: rtl/xtrig_router_chk.sv
module xtrig_router_chk #(
  parameter int          N_TO       = 8,
  parameter int          N_CH       = 4,
  parameter int          AW         = 12,
  parameter logic [31:0] UNLOCK_KEY = 32'h5EC0_17AB
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [N_TO-1:0] trig_out,
  input logic            en_q,
  input logic            locked_q,
  input logic [N_CH-1:0] pulse_q
);
  logic [N_TO-1:0] ack;
  assign ack = (bus_wr && !locked_q && bus_addr == AW'(12'h010)) ? bus_wdata[N_TO-1:0] : '0;

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_out) |=> ((trig_out & $past(trig_out & ~ack)) == $past(trig_out & ~ack)));

  // R7
  no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> ((trig_out & ~$past(trig_out)) == '0));

  // R2
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && bus_wr && bus_addr == AW'(12'h000)) |=> $stable(en_q));

  // R2
  lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(12'hFB0)) |=> (locked_q == ($past(bus_wdata) != UNLOCK_KEY)));

  // R9
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulse_q != '0) && !(bus_wr && !locked_q && bus_addr == AW'(12'h01C))) |=> (pulse_q == '0));
endmodule

bind xtrig_router xtrig_router_chk #(.N_TO(N_TO), .N_CH(N_CH), .AW(AW), .UNLOCK_KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .trig_out(trig_out), .en_q(en_q), .locked_q(locked_q), .pulse_q(pulse_q)
);

// File: tb/xtrig_router_tb.sv
`timescale 1ns/1ps
module xtrig_router_tb;
  localparam logic [31:0] KEY = 32'h5EC0_17AB;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  trig_in = '0, trig_out;

  always #2 clk = ~clk;

  xtrig_router u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .trig_in(trig_in), .trig_out(trig_out)
  );

  typedef struct { string tag; bit is_out; logic [31:0] exp; } item_t;
  item_t q[$];
  item_t it;
  logic [31:0] act;
  int checks = 0, fails = 0;
  bit done = 0;

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      it = q.pop_front();
      act = it.is_out ? 32'(trig_out) : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_wr = 1'b0; bus_addr = a;
    q.push_back('{tag, 1'b0, e});
  endtask

  task automatic chk_to(input logic [7:0] e, input string tag);
    @(negedge clk);
    q.push_back('{tag, 1'b1, 32'(e)});
  endtask

  task automatic set_trig(input logic [7:0] v);
    @(negedge clk); trig_in = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_rd(12'hFB4, 32'h3, "R1 lock status");
    chk_rd(12'h000, 32'h0, "R1 control");
    chk_rd(12'h020, 32'h0, "R1 in mask");
    chk_to(8'h00, "R1 trig_out");
    wr(12'h000, 32'h1);
    chk_rd(12'h000, 32'h0, "R2 locked ctrl write");
    wr(12'h020, 32'h5);
    chk_rd(12'h020, 32'h0, "R2 locked mask write");
    wr(12'hFB0, KEY);
    chk_rd(12'hFB4, 32'h1, "R2 unlocked status");
    wr(12'h02C, 32'hFFFF_FFF6);
    chk_rd(12'h02C, 32'h6, "R3 in mask 3");
    wr(12'h0B4, 32'h2);
    chk_rd(12'h0B4, 32'h2, "R3 out mask 5");
    set_trig(8'h08);
    chk_to(8'h00, "R7 disabled");
    chk_rd(12'h130, 32'h08, "R10 trig in status");
    chk_rd(12'h138, 32'h6, "R10 chan in status");
    set_trig(8'h00);
    wr(12'h000, 32'h1);
    chk_rd(12'h000, 32'h1, "R4 enable readback");
    set_trig(8'h08);
    chk_to(8'h20, "R4 routed");
    set_trig(8'h00);
    chk_to(8'h20, "R5 sticky");
    chk_rd(12'h134, 32'h20, "R10 trig out status");
    wr(12'h010, 32'h10);
    chk_to(8'h20, "R5 other ack");
    wr(12'h010, 32'h20);
    chk_to(8'h00, "R5 ack clears");
    set_trig(8'h08);
    wr(12'h010, 32'h20);
    chk_to(8'h20, "R6 hit beats ack");
    set_trig(8'h00);
    wr(12'h010, 32'h20);
    chk_to(8'h00, "R6 ack after drop");
    wr(12'h0A0, 32'h8);
    wr(12'h014, 32'h8);
    chk_rd(12'h13C, 32'h8, "R8 held chan status");
    chk_rd(12'h014, 32'h8, "R8 held readback");
    chk_to(8'h01, "R8 held drives out");
    wr(12'h018, 32'h8);
    chk_rd(12'h13C, 32'h0, "R8 released");
    wr(12'h010, 32'h1);
    chk_to(8'h00, "R8 no refire");
    wr(12'h0BC, 32'h4);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h01C; bus_wdata = 32'h4;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 12'h13C;
    q.push_back('{"R9 pulse cycle", 1'b0, 32'h4});
    chk_rd(12'h13C, 32'h0, "R9 pulse gone");
    chk_to(8'h80, "R9 pulse latched out");
    chk_rd(12'h200, 32'h0, "R11 unmapped");
    chk_rd(12'hFE0, 32'h33, "R11 id 0");
    chk_rd(12'hFFC, 32'h0D, "R11 id 7");
    wr(12'hFB0, 32'h0);
    chk_rd(12'hFB4, 32'h3, "R2 relocked");
    wr(12'h000, 32'h0);
    chk_rd(12'h000, 32'h1, "R2 relocked ctrl write");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule